// File: doc/BRIEF.md
# Parallel Port Extended Control Register

This block holds the extended control register of a FIFO-backed parallel port and generates the port's service logic from it. The host reads and writes the register over a plain byte-wide access. The block watches how full the neighbouring byte FIFO is, the peripheral's fault line, the DMA terminal-count strobe and the requested transfer direction. From these it produces:

- the current port mode;
- the FIFO status read bits;
- single-cycle service and error interrupt pulses;
- a DMA request together with the enable that drives the request pad;
- the transfer direction, forced where the mode requires it.

Register layout, most significant bit first:

| Bits | Field | Access |
|------|-------|--------|
| 7:5 | mode | read/write, with restrictions |
| 4 | error-interrupt enable, active low | read/write |
| 3 | DMA enable | read/write |
| 2 | service-interrupt enable, active low | read/write |
| 1 | FIFO full | read-only |
| 0 | FIFO empty | read-only |

Mode codes:

| Code | Mode |
|------|------|
| 000 | plain output |
| 001 | bidirectional, no FIFO |
| 010 | FIFO output |
| 011 | extended-capability mode (ECP) |
| 100 | enhanced parallel port (EPP) |
| 101 | reserved |
| 110 | FIFO test |
| 111 | configuration access |

Modes 000 and 001 act as hubs. The port can leave a hub for any mode, but from any other mode it can only return to a hub. After each service interrupt the service enable sets itself again, so software must re-arm it for each block of transfers.

Top module: `pp_ext_ctrl`

## Requirements
- R1: After reset the register reads 8'h95 (mode 100, bit 4 = 1, bit 3 = 0, bit 2 = 1, bit 1 = 0, bit 0 = 1).
- R2: When the current mode is 000 or 001, a write loads bits 7:5 with any written value.
- R3: When the current mode is anything else, a write loads bits 7:5 only if the written value is 000 or 001. Otherwise the mode is unchanged.
- R4: Bit 0 reads 1 when the FIFO count is 0 and 0 otherwise, but only in modes 010, 011 and 110. In every other mode it reads 1.
- R5: Bit 1 reads 1 when the FIFO count equals DEPTH (16) and 0 otherwise, but only in modes 010, 011 and 110. In every other mode it reads 0.
- R6: A write loads bits 4:2 from the written data. Written bits 1:0 have no effect on what bits 1:0 read.
- R7: The service condition depends on bit 3 and the effective direction:
  - bit 3 = 1: the DMA terminal-count input.
  - bit 3 = 0, direction 0: at least THRESH (8) free FIFO locations.
  - bit 3 = 0, direction 1: at least THRESH filled locations.
- R8: If the service condition holds at a clock edge while bit 2 = 0, svc_irq is high for exactly the following cycle and bit 2 reads 1 from that same edge. A write in that cycle does not stop bit 2 from being set.
- R9: dma_oe equals bit 3. dma_req is 1 exactly when bit 3 = 1 and bit 2 = 0.
- R10: If bit 4 = 0 and the mode is 011, a falling edge on fault_n gives exactly one err_irq cycle, three clock edges after the edge. A steady low on fault_n gives no further pulses.
- R11: dir_out is 0 in modes 000 and 010. In all other modes it equals dir_in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| fifo_count | input | $clog2(DEPTH+1) | Bytes currently held in the FIFO |
| fault_n | input | 1 | Peripheral fault, active low, asynchronous |
| dma_tc | input | 1 | DMA terminal count |
| dir_in | input | 1 | Requested transfer direction (1 = toward host) |
| mode_o | output | 3 | Current mode field |
| fifo_empty_o | output | 1 | FIFO-empty read bit |
| fifo_full_o | output | 1 | FIFO-full read bit |
| svc_irq | output | 1 | Service interrupt pulse |
| err_irq | output | 1 | Error interrupt pulse |
| dma_req | output | 1 | DMA request |
| dma_oe | output | 1 | Drive enable for the DMA request pad |
| dir_out | output | 1 | Effective transfer direction |

## Verification
Every stored field is visible on rd_data, so a wrong mode or enable bit appears on the read value in the cycle after the write that caused it. A wrong service enable shows up at once on dma_req, and a missed re-arm shows up as a second svc_irq pulse one cycle later. Errors in the fault synchroniser or edge detector show up as err_irq arriving at the wrong edge or repeating while fault_n stays low. The bench compares all outputs against its own model on every cycle, so any of these faults is caught within a cycle of first appearing.

// File: rtl/pp_ext_pkg.sv
package pp_ext_pkg;

    typedef enum logic [2:0] {
        MD_PLAIN = 3'b000,
        MD_BIDIR = 3'b001,
        MD_FOUT  = 3'b010,
        MD_ECP   = 3'b011,
        MD_EPP   = 3'b100,
        MD_RSVD  = 3'b101,
        MD_FTEST = 3'b110,
        MD_CONF  = 3'b111
    } port_mode_e;

    typedef struct packed {
        logic [2:0] mode;
        logic       err_en_n;
        logic       dma_en;
        logic       svc_en_n;
        logic       svc_irq;
        logic       err_irq;
    } ctl_state_t;

    localparam ctl_state_t CTL_RESET = '{
        mode:     MD_EPP,
        err_en_n: 1'b1,
        dma_en:   1'b0,
        svc_en_n: 1'b1,
        svc_irq:  1'b0,
        err_irq:  1'b0
    };

    function automatic logic is_hub(input logic [2:0] m);
        return (m == MD_PLAIN) || (m == MD_BIDIR);
    endfunction

    function automatic logic uses_fifo(input logic [2:0] m);
        return (m == MD_FOUT) || (m == MD_ECP) || (m == MD_FTEST);
    endfunction

    function automatic logic [2:0] pick_mode(input logic [2:0] cur, input logic [2:0] req);
        if (is_hub(cur) || is_hub(req)) return req;
        return cur;
    endfunction

endpackage

// File: rtl/pp_fifo_stat.sv
module pp_fifo_stat
    import pp_ext_pkg::*;
#(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned THRESH = 8,
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic [2:0]    mode,
    input  logic [CW-1:0] count,
    input  logic          dma_en,
    input  logic          dir_eff,
    input  logic          dma_tc,
    output logic          empty_bit,
    output logic          full_bit,
    output logic          svc_cond
);
    localparam logic [CW-1:0] DEPTH_C  = CW'(DEPTH);
    localparam logic [CW-1:0] THRESH_C = CW'(THRESH);

    logic [CW-1:0] free_slots;
    logic          fifo_active;

    always_comb begin
        fifo_active = uses_fifo(mode);
        free_slots  = DEPTH_C - count;
        empty_bit   = fifo_active ? (count == '0) : 1'b1;
        full_bit    = fifo_active ? (count == DEPTH_C) : 1'b0;
        if (dma_en) begin
            svc_cond = dma_tc;
        end else if (dir_eff) begin
            svc_cond = (count >= THRESH_C);
        end else begin
            svc_cond = (free_slots >= THRESH_C);
        end
    end

endmodule

// File: rtl/pp_fault_edge.sv
module pp_fault_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_n,
    output logic fall
);
    typedef struct packed {
        logic meta;
        logic sync;
        logic prev;
    } fe_state_t;

    fe_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = fault_n;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
        fall      = st_q.prev & ~st_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{meta: 1'b1, sync: 1'b1, prev: 1'b1};
        else        st_q <= st_d;
    end

    a_r10_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/pp_ext_ctrl.sv
module pp_ext_ctrl
    import pp_ext_pkg::*;
#(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned THRESH = 8,
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    output logic [7:0]    rd_data,
    input  logic [CW-1:0] fifo_count,
    input  logic          fault_n,
    input  logic          dma_tc,
    input  logic          dir_in,
    output logic [2:0]    mode_o,
    output logic          fifo_empty_o,
    output logic          fifo_full_o,
    output logic          svc_irq,
    output logic          err_irq,
    output logic          dma_req,
    output logic          dma_oe,
    output logic          dir_out
);
    ctl_state_t st_d, st_q;
    logic       dir_eff;
    logic       svc_cond;
    logic       fault_fall;
    logic       empty_bit, full_bit;

    assign dir_eff = ((st_q.mode == MD_PLAIN) || (st_q.mode == MD_FOUT)) ? 1'b0 : dir_in;

    pp_fifo_stat #(.DEPTH(DEPTH), .THRESH(THRESH)) u_stat (
        .mode      (st_q.mode),
        .count     (fifo_count),
        .dma_en    (st_q.dma_en),
        .dir_eff   (dir_eff),
        .dma_tc    (dma_tc),
        .empty_bit (empty_bit),
        .full_bit  (full_bit),
        .svc_cond  (svc_cond)
    );

    pp_fault_edge u_fault (
        .clk     (clk),
        .rst_n   (rst_n),
        .fault_n (fault_n),
        .fall    (fault_fall)
    );

    always_comb begin
        st_d         = st_q;
        st_d.svc_irq = svc_cond & ~st_q.svc_en_n;
        st_d.err_irq = fault_fall & ~st_q.err_en_n & (st_q.mode == MD_ECP);
        if (wr_en) begin
            st_d.mode     = pick_mode(st_q.mode, wr_data[7:5]);
            st_d.err_en_n = wr_data[4];
            st_d.dma_en   = wr_data[3];
            st_d.svc_en_n = wr_data[2];
        end
        if (st_d.svc_irq) st_d.svc_en_n = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CTL_RESET;
        else        st_q <= st_d;
    end

    assign rd_data      = {st_q.mode, st_q.err_en_n, st_q.dma_en, st_q.svc_en_n, full_bit, empty_bit};
    assign mode_o       = st_q.mode;
    assign fifo_empty_o = empty_bit;
    assign fifo_full_o  = full_bit;
    assign svc_irq      = st_q.svc_irq;
    assign err_irq      = st_q.err_irq;
    assign dma_oe       = st_q.dma_en;
    assign dma_req      = st_q.dma_en & ~st_q.svc_en_n;
    assign dir_out      = dir_eff;

    a_r8_svc_single: assert property (@(posedge clk) disable iff (!rst_n)
        svc_irq |=> !svc_irq);
    a_r8_svc_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        svc_irq |-> rd_data[2]);
    a_r3_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_hub($past(mode_o)) && (mode_o != $past(mode_o))) |-> is_hub(mode_o));
    a_r9_dma_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_oe |-> !dma_req);
    a_r11_dir_forced: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_o == MD_PLAIN) || (mode_o == MD_FOUT)) |-> !dir_out);
    a_r5_status_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_empty_o && fifo_full_o));
    a_r10_err_ecp_only: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> ($past(mode_o) == MD_ECP));

endmodule

// File: tb/tb_pp_ext_ctrl.sv
module tb_pp_ext_ctrl;
    localparam int DEPTH  = 16;
    localparam int THRESH = 8;
    localparam int CW     = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_data = '0;
    logic [7:0]    rd_data;
    logic [CW-1:0] fifo_count = '0;
    logic          fault_n = 1'b1;
    logic          dma_tc = 1'b0;
    logic          dir_in = 1'b0;
    logic [2:0]    mode_o;
    logic          fifo_empty_o, fifo_full_o, svc_irq, err_irq, dma_req, dma_oe, dir_out;

    int checks = 0;
    int failures = 0;
    int err_pulses = 0;

    // reference model state
    logic [2:0] m_mode;
    logic m_err_n, m_dma, m_svc_n, m_svc_irq, m_err_irq, m_s1, m_s2, m_s3;

    always #4 clk = ~clk;

    pp_ext_ctrl #(.DEPTH(DEPTH), .THRESH(THRESH)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .fifo_count(fifo_count), .fault_n(fault_n), .dma_tc(dma_tc), .dir_in(dir_in),
        .mode_o(mode_o), .fifo_empty_o(fifo_empty_o), .fifo_full_o(fifo_full_o),
        .svc_irq(svc_irq), .err_irq(err_irq), .dma_req(dma_req), .dma_oe(dma_oe),
        .dir_out(dir_out)
    );

    function automatic logic hub(input logic [2:0] m);
        return m == 3'b000 || m == 3'b001;
    endfunction

    function automatic logic fifo_md(input logic [2:0] m);
        return m == 3'b010 || m == 3'b011 || m == 3'b110;
    endfunction

    function automatic logic exp_dir();
        return (m_mode == 3'b000 || m_mode == 3'b010) ? 1'b0 : dir_in;
    endfunction

    function automatic logic exp_cond();
        if (m_dma) return dma_tc;
        if (exp_dir()) return int'(fifo_count) >= THRESH;
        return (DEPTH - int'(fifo_count)) >= THRESH;
    endfunction

    function automatic logic [7:0] exp_rd();
        logic e, f;
        e = fifo_md(m_mode) ? (fifo_count == 0) : 1'b1;
        f = fifo_md(m_mode) ? (int'(fifo_count) == DEPTH) : 1'b0;
        return {m_mode, m_err_n, m_dma, m_svc_n, f, e};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_mode = 3'b100; m_err_n = 1'b1; m_dma = 1'b0; m_svc_n = 1'b1;
        m_svc_irq = 1'b0; m_err_irq = 1'b0; m_s1 = 1'b1; m_s2 = 1'b1; m_s3 = 1'b1;
    endtask

    task automatic compare_all();
        chk("R2 R3 R4 R5 R6 rd_data", 32'(rd_data), 32'(exp_rd()));
        chk("R2 R3 mode_o", 32'(mode_o), 32'(m_mode));
        chk("R7 R8 svc_irq", 32'(svc_irq), 32'(m_svc_irq));
        chk("R10 err_irq", 32'(err_irq), 32'(m_err_irq));
        chk("R9 dma_req", 32'(dma_req), 32'(m_dma & ~m_svc_n));
        chk("R9 dma_oe", 32'(dma_oe), 32'(m_dma));
        chk("R11 dir_out", 32'(dir_out), 32'(exp_dir()));
    endtask

    // inputs are set at the falling edge; one rising edge is taken; outputs compared at the next falling edge
    task automatic step();
        logic [2:0] n_mode;
        logic n_err_n, n_dma, n_svc_n, n_svc_irq, n_err_irq;
        n_mode = m_mode; n_err_n = m_err_n; n_dma = m_dma; n_svc_n = m_svc_n;
        n_svc_irq = exp_cond() & ~m_svc_n;
        n_err_irq = (m_s3 & ~m_s2) & ~m_err_n & (m_mode == 3'b011);
        if (wr_en) begin
            if (hub(m_mode) || hub(wr_data[7:5])) n_mode = wr_data[7:5];
            n_err_n = wr_data[4]; n_dma = wr_data[3]; n_svc_n = wr_data[2];
        end
        if (n_svc_irq) n_svc_n = 1'b1;
        @(posedge clk);
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = fault_n;
        m_mode = n_mode; m_err_n = n_err_n; m_dma = n_dma; m_svc_n = n_svc_n;
        m_svc_irq = n_svc_irq; m_err_irq = n_err_irq;
        @(negedge clk);
        if (err_irq) err_pulses++;
        compare_all();
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        chk("R1 reset read value", 32'(rd_data), 32'h95);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset read after release", 32'(rd_data), 32'h95);
        compare_all();

        // R3: from EPP, a non-hub target is refused; a hub target is taken
        wr(8'b011_1_0_1_00);
        chk("R3 refused change from 100", 32'(mode_o), 32'b100);
        wr(8'b000_1_0_1_11);
        chk("R3 return to hub", 32'(mode_o), 32'b000);
        chk("R6 bits 1:0 ignore write", 32'(rd_data[1:0]), 32'b01);
        // R2: from a hub, anything is taken
        wr(8'b110_1_0_1_00);
        chk("R2 hub to test mode", 32'(mode_o), 32'b110);
        wr(8'b111_1_0_1_00);
        chk("R3 refused 111 from 110", 32'(mode_o), 32'b110);
        wr(8'b001_1_0_1_00);
        chk("R3 110 to 001", 32'(mode_o), 32'b001);
        wr(8'b101_1_0_1_00);
        chk("R2 hub to reserved", 32'(mode_o), 32'b101);
        wr(8'b000_1_0_1_00);

        // R4 R5: FIFO-output mode, empty and full corners
        wr(8'b010_1_0_1_00);
        fifo_count = '0; step();
        chk("R4 empty in fifo mode", 32'(rd_data[1:0]), 32'b01);
        fifo_count = CW'(DEPTH); step();
        chk("R5 full in fifo mode", 32'(rd_data[1:0]), 32'b10);
        wr(8'b000_1_0_1_00);
        step();
        chk("R5 R4 forced in plain mode", 32'(rd_data[1:0]), 32'b01);

        // R7 R8: ECP, direction 1, 8 filled: one pulse and auto re-arm
        wr(8'b011_1_0_1_00);
        dir_in = 1'b1; fifo_count = CW'(THRESH);
        wr(8'b011_1_0_0_00);
        chk("R9 dma off no request", 32'(dma_req), 0);
        step();
        chk("R8 service pulse", 32'(svc_irq), 1);
        chk("R8 bit2 set by hardware", 32'(rd_data[2]), 1);
        step();
        chk("R8 pulse one cycle", 32'(svc_irq), 0);
        // R7: below threshold, no pulse
        fifo_count = CW'(THRESH - 1);
        wr(8'b011_1_0_0_00);
        step(); step();
        chk("R7 below threshold idle", 32'(svc_irq), 0);
        // R9 R7: DMA mode waits for terminal count
        wr(8'b011_1_1_0_00);
        chk("R9 request while armed", 32'(dma_req), 1);
        dma_tc = 1'b1; step(); dma_tc = 1'b0;
        chk("R7 terminal count pulse", 32'(svc_irq), 1);
        chk("R9 request dropped", 32'(dma_req), 0);

        // R10: ECP, error enabled, steady low fault gives one pulse
        wr(8'b011_0_0_1_00);
        err_pulses = 0;
        fault_n = 1'b0;
        repeat (8) step();
        chk("R10 single pulse on steady low", 32'(err_pulses), 1);
        fault_n = 1'b1; repeat (4) step();
        wr(8'b011_1_0_1_00);
        err_pulses = 0; fault_n = 1'b0;
        repeat (6) step();
        chk("R10 disabled no pulse", 32'(err_pulses), 0);
        fault_n = 1'b1; repeat (4) step();

        // R11: direction forced in plain mode
        wr(8'b000_1_0_1_00);
        dir_in = 1'b1; step();
        chk("R11 forced low", 32'(dir_out), 0);

        // random mix
        for (int i = 0; i < 6000; i++) begin
            wr_en = ($urandom % 4) == 0;
            wr_data = 8'($urandom);
            if (($urandom % 3) == 0) wr_data[7:5] = 3'($urandom % 2);
            fifo_count = CW'($urandom % (DEPTH + 1));
            dir_in = 1'($urandom);
            dma_tc = ($urandom % 5) == 0;
            if (($urandom % 8) == 0) fault_n = ~fault_n;
            step();
        end
        wr_en = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule